// File: doc/BRIEF.md
# Low-Power Mode Sequencer with Debug Gating

This block keeps track of the power mode a chip core is in and moves it between modes. The modes are normal run, very-low-power run, very-low-power stop, low-leakage stop and a debug halt. Software asks for a stop by raising a stop request together with a target mode code. The sequencer checks that the target is legal, switches mode on the next clock edge and sets the regulator mode, the CPU clock enable and the peripheral retention outputs to match. Low-leakage stop ends when an enabled wakeup source fires. The sequencer then returns to normal run and latches a per-source flag, which software polls and clears.

Background debug is taken into account at the moment a stop begins. Debug support is granted only when all four of these hold at that edge: the part is unsecured, debug is enabled, the debug control bit is set, and the core is in normal run. When support is granted, the CPU clock keeps running and the regulator keeps the state it had before the stop. While a stop mode is active, incoming debug commands are filtered. The wake command moves the core into halt. A memory-with-status command reports a stop/wait error and performs no memory access. Every other command is rejected. In halt, every command is accepted, and a resume command returns the core to normal run.

Top module: `lpm_seq`

## Requirements
- R1: After reset, the mode is run (code 0), the regulator code is full (0), the CPU clock enable is 1, retention is 0, all wake flags are 0, the wake interrupt is 0 and all command result pulses are 0.
- R2: A stop request in run (0) or very-low-power run (1) with target 2 (very-low-power stop) or 3 (low-leakage stop) enters that mode on the next edge. Without debug support, the regulator code becomes stop (2) and the CPU clock enable becomes 0. Retention is 1 only in mode 3.
- R3: A stop request in run or very-low-power run whose target is any code other than 2 or 3 leaves the mode unchanged. The stop-error output is 1 for exactly one cycle.
- R4: In run, a high low-power-run enable moves the mode to 1 with regulator code low-power (1). In mode 1, a low enable moves the mode back to 0 with regulator code 0. A stop request takes priority over this.
- R5: Debug support is granted at stop entry only if the part is unsecured, debug is enabled, the debug control bit is set and the mode is 0. When it is granted, the CPU clock enable stays 1 in stop and the regulator code keeps its prior value. Stops entered from mode 1 never get debug support.
- R6: In a stop mode with debug support, a command with op 1 (memory with status) gives a one-cycle error pulse and no execute pulse, and ops 2 and 3 give a reject pulse. In a stop mode without debug support, every command gives a reject pulse and the mode is unchanged.
- R7: In a stop mode with debug support, op 0 (wake to background) gives an execute pulse and moves the mode to halt (4). In halt, every op gives an execute pulse, and op 3 (resume) returns the mode to 0.
- R8: In low-leakage stop, a wake source whose enable bit is set returns the mode to 0 with regulator code 0, sets that source's flag and raises the wake interrupt. A source whose enable bit is clear has no effect.
- R9: Wake flags stay set until the matching flag-clear bit is written as 1. Wake sources have no effect on the mode or the flags outside low-leakage stop.
- R10: Asserting reset while in very-low-power stop returns the mode to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| stop_req | input | 1 | Stop request strobe |
| stop_tgt | input | 3 | Target mode code for the stop request |
| lpr_en | input | 1 | Low-power-run enable level |
| secured | input | 1 | Part is secured |
| dbg_en | input | 1 | Background debug enabled |
| dbg_ctl | input | 1 | Debug control bit for stop |
| wk_src | input | NSRC | Wakeup source events |
| wk_en | input | NSRC | Wakeup source enables |
| flag_clr | input | NSRC | Write-1-to-clear for wake flags |
| cmd_valid | input | 1 | Debug command strobe |
| cmd_op | input | 2 | Debug command op: 0 wake, 1 memory with status, 2 other, 3 resume |
| mode_o | output | 3 | Current mode: 0 run, 1 low-power run, 2 very-low-power stop, 3 low-leakage stop, 4 halt |
| reg_mode_o | output | 2 | Regulator code: 0 full, 1 low-power, 2 stop |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| retain_o | output | 1 | Peripheral retention |
| stop_err_o | output | 1 | Illegal stop target pulse |
| wk_flags_o | output | NSRC | Per-source wake flags |
| wk_irq_o | output | 1 | Pending wake interrupt |
| cmd_exec_o | output | 1 | Command executed pulse |
| cmd_err_o | output | 1 | Stop/wait error status pulse |
| cmd_rej_o | output | 1 | Command rejected pulse |

## Verification
A wrong mode register shows at the mode port, and at the regulator and clock-enable outputs, on the first clock edge after the stimulus. A wrongly latched debug-support bit shows two ways. The clock enable and regulator code are wrong right after stop entry. A single following command also comes back with the wrong result pulse one cycle later. Flag corruption appears on the flag and interrupt ports in the wake cycle and persists until a clear, so hold and clear cycles are checked separately.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   typedef enum logic [2:0] {
      M_RUN   = 3'd0,
      M_LPRUN = 3'd1,
      M_VSTOP = 3'd2,
      M_LSTOP = 3'd3,
      M_HALT  = 3'd4
   } pmode_e;

   localparam logic [1:0] RG_FULL = 2'd0;
   localparam logic [1:0] RG_LOW  = 2'd1;
   localparam logic [1:0] RG_STOP = 2'd2;

   localparam logic [1:0] OP_WAKE  = 2'd0;
   localparam logic [1:0] OP_MEMST = 2'd1;
   localparam logic [1:0] OP_OTHER = 2'd2;
   localparam logic [1:0] OP_GO    = 2'd3;

   function automatic logic is_stop(input logic [2:0] m);
      return (m == M_VSTOP) || (m == M_LSTOP);
   endfunction

endpackage

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
   import lpm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       stop_req,
   input  logic [2:0] stop_tgt,
   input  logic       lpr_en,
   input  logic       secured,
   input  logic       dbg_en,
   input  logic       dbg_ctl,
   input  logic       wake_hit,
   input  logic       halt_req,
   input  logic       run_req,
   output logic [2:0] mode,
   output logic [1:0] reg_mode,
   output logic       dbg_act,
   output logic       stop_err,
   output logic       clk_en,
   output logic       retain
);

   pmode_e     cur, nxt;
   logic [1:0] rg_q, rg_d;
   logic       da_q, da_d;
   logic       err_d;
   logic       tgt_ok, dbg_qual;

   assign tgt_ok   = (stop_tgt == M_VSTOP) || (stop_tgt == M_LSTOP);
   assign dbg_qual = !secured && dbg_en && dbg_ctl && (cur == M_RUN);

   always_comb begin
      nxt   = cur;
      rg_d  = rg_q;
      da_d  = da_q;
      err_d = 1'b0;
      unique case (cur)
         M_RUN, M_LPRUN: begin
            if (stop_req) begin
               if (tgt_ok) begin
                  nxt  = pmode_e'(stop_tgt);
                  da_d = dbg_qual;
                  rg_d = dbg_qual ? rg_q : RG_STOP;
               end else begin
                  err_d = 1'b1;
               end
            end else if (cur == M_RUN && lpr_en) begin
               nxt  = M_LPRUN;
               rg_d = RG_LOW;
            end else if (cur == M_LPRUN && !lpr_en) begin
               nxt  = M_RUN;
               rg_d = RG_FULL;
            end
         end
         M_VSTOP, M_LSTOP: begin
            if (cur == M_LSTOP && wake_hit) begin
               nxt  = M_RUN;
               rg_d = RG_FULL;
               da_d = 1'b0;
            end else if (halt_req) begin
               nxt  = M_HALT;
               rg_d = RG_FULL;
               da_d = 1'b0;
            end
         end
         M_HALT: begin
            if (run_req) begin
               nxt  = M_RUN;
               rg_d = RG_FULL;
            end
         end
         default: begin
            nxt  = M_RUN;
            rg_d = RG_FULL;
            da_d = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur      <= M_RUN;
         rg_q     <= RG_FULL;
         da_q     <= 1'b0;
         stop_err <= 1'b0;
      end else begin
         cur      <= nxt;
         rg_q     <= rg_d;
         da_q     <= da_d;
         stop_err <= err_d;
      end
   end

   assign mode     = cur;
   assign reg_mode = rg_q;
   assign dbg_act  = da_q;
   assign clk_en   = !is_stop(cur) || da_q;
   assign retain   = (cur == M_LSTOP);

endmodule

// File: rtl/lpm_wake.sv
module lpm_wake #(
   parameter int NSRC = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_lls,
   input  logic [NSRC-1:0] src,
   input  logic [NSRC-1:0] en,
   input  logic [NSRC-1:0] clr,
   output logic            hit,
   output logic [NSRC-1:0] flags,
   output logic            irq
);

   logic [NSRC-1:0] fire;

   assign fire = in_lls ? (src & en) : '0;
   assign hit  = |fire;
   assign irq  = |flags;

   for (genvar i = 0; i < NSRC; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flags[i] <= 1'b0;
         else if (fire[i])
            flags[i] <= 1'b1;
         else if (clr[i])
            flags[i] <= 1'b0;
      end
   end

endmodule

// File: rtl/lpm_dbg_filter.sv
module lpm_dbg_filter
   import lpm_pkg::*;
#(
   parameter bit REG_OUT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [1:0] cmd_op,
   input  logic [2:0] mode,
   input  logic       dbg_act,
   output logic       halt_req,
   output logic       run_req,
   output logic       exec_o,
   output logic       err_o,
   output logic       rej_o
);

   logic exec_d, err_d, rej_d;

   always_comb begin
      exec_d   = 1'b0;
      err_d    = 1'b0;
      rej_d    = 1'b0;
      halt_req = 1'b0;
      run_req  = 1'b0;
      if (cmd_valid) begin
         if (is_stop(mode)) begin
            if (dbg_act && cmd_op == OP_WAKE) begin
               exec_d   = 1'b1;
               halt_req = 1'b1;
            end else if (dbg_act && cmd_op == OP_MEMST) begin
               err_d = 1'b1;
            end else begin
               rej_d = 1'b1;
            end
         end else begin
            exec_d  = 1'b1;
            run_req = (mode == M_HALT) && (cmd_op == OP_GO);
         end
      end
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            exec_o <= 1'b0;
            err_o  <= 1'b0;
            rej_o  <= 1'b0;
         end else begin
            exec_o <= exec_d;
            err_o  <= err_d;
            rej_o  <= rej_d;
         end
      end
   end else begin : g_comb
      assign exec_o = exec_d;
      assign err_o  = err_d;
      assign rej_o  = rej_d;
   end

endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
   import lpm_pkg::*;
#(
   parameter int NSRC    = 4,
   parameter bit REG_CMD = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            stop_req,
   input  logic [2:0]      stop_tgt,
   input  logic            lpr_en,
   input  logic            secured,
   input  logic            dbg_en,
   input  logic            dbg_ctl,
   input  logic [NSRC-1:0] wk_src,
   input  logic [NSRC-1:0] wk_en,
   input  logic [NSRC-1:0] flag_clr,
   input  logic            cmd_valid,
   input  logic [1:0]      cmd_op,
   output logic [2:0]      mode_o,
   output logic [1:0]      reg_mode_o,
   output logic            cpu_clk_en_o,
   output logic            retain_o,
   output logic            stop_err_o,
   output logic [NSRC-1:0] wk_flags_o,
   output logic            wk_irq_o,
   output logic            cmd_exec_o,
   output logic            cmd_err_o,
   output logic            cmd_rej_o
);

   if (NSRC < 1 || NSRC > 32) begin : g_bad_nsrc
      $error("lpm_seq: NSRC must be in 1..32");
   end

   logic wake_hit, halt_req, run_req, dbg_act;

   lpm_mode_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .stop_req (stop_req),
      .stop_tgt (stop_tgt),
      .lpr_en   (lpr_en),
      .secured  (secured),
      .dbg_en   (dbg_en),
      .dbg_ctl  (dbg_ctl),
      .wake_hit (wake_hit),
      .halt_req (halt_req),
      .run_req  (run_req),
      .mode     (mode_o),
      .reg_mode (reg_mode_o),
      .dbg_act  (dbg_act),
      .stop_err (stop_err_o),
      .clk_en   (cpu_clk_en_o),
      .retain   (retain_o)
   );

   lpm_wake #(.NSRC(NSRC)) u_wake (
      .clk    (clk),
      .rst_n  (rst_n),
      .in_lls (mode_o == M_LSTOP),
      .src    (wk_src),
      .en     (wk_en),
      .clr    (flag_clr),
      .hit    (wake_hit),
      .flags  (wk_flags_o),
      .irq    (wk_irq_o)
   );

   lpm_dbg_filter #(.REG_OUT(REG_CMD)) u_dbg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .mode      (mode_o),
      .dbg_act   (dbg_act),
      .halt_req  (halt_req),
      .run_req   (run_req),
      .exec_o    (cmd_exec_o),
      .err_o     (cmd_err_o),
      .rej_o     (cmd_rej_o)
   );

endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] mode_o,
   input logic [1:0] reg_mode_o,
   input logic       cpu_clk_en_o,
   input logic       stop_err_o,
   input logic       wk_irq_o,
   input logic       cmd_exec_o,
   input logic       cmd_err_o,
   input logic       cmd_rej_o
);

   AST_STOP_ERR_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_err_o |-> (mode_o == $past(mode_o)));                          // R3

   AST_STOP_REG_NO_DEBUG: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_o == 3'd2 || mode_o == 3'd3) && !cpu_clk_en_o) |-> (reg_mode_o == 2'd2)); // R2

   AST_CMD_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_exec_o, cmd_err_o, cmd_rej_o}));                       // R6

   AST_ERR_ONLY_IN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err_o |-> ($past(mode_o) == 3'd2 || $past(mode_o) == 3'd3));     // R6

   AST_HALT_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd4 && $past(mode_o) != 3'd4) |->
         (($past(mode_o) == 3'd2 || $past(mode_o) == 3'd3) && cmd_exec_o)); // R7

   AST_LLS_WAKE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd0 && $past(mode_o) == 3'd3) |-> wk_irq_o);              // R8

endmodule

bind lpm_seq lpm_seq_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mode_o       (mode_o),
   .reg_mode_o   (reg_mode_o),
   .cpu_clk_en_o (cpu_clk_en_o),
   .stop_err_o   (stop_err_o),
   .wk_irq_o     (wk_irq_o),
   .cmd_exec_o   (cmd_exec_o),
   .cmd_err_o    (cmd_err_o),
   .cmd_rej_o    (cmd_rej_o)
);

// File: tb/tb_lpm_seq.sv
`timescale 1ns/1ps
module tb_lpm_seq;

   localparam int NSRC = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            stop_req = 1'b0;
   logic [2:0]      stop_tgt = '0;
   logic            lpr_en = 1'b0;
   logic            secured = 1'b1;
   logic            dbg_en = 1'b0;
   logic            dbg_ctl = 1'b0;
   logic [NSRC-1:0] wk_src = '0;
   logic [NSRC-1:0] wk_en = '0;
   logic [NSRC-1:0] flag_clr = '0;
   logic            cmd_valid = 1'b0;
   logic [1:0]      cmd_op = '0;
   logic [2:0]      mode_o;
   logic [1:0]      reg_mode_o;
   logic            cpu_clk_en_o, retain_o, stop_err_o, wk_irq_o;
   logic [NSRC-1:0] wk_flags_o;
   logic            cmd_exec_o, cmd_err_o, cmd_rej_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   lpm_seq #(.NSRC(NSRC)) dut (.*);

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tick(); tick();
      rst_n = 1'b1;
      tick();
   endtask

   task automatic stop_to(input logic [2:0] t);
      stop_req = 1'b1; stop_tgt = t;
      tick();
      stop_req = 1'b0;
   endtask

   task automatic cmd(input logic [1:0] op);
      cmd_valid = 1'b1; cmd_op = op;
      tick();
      cmd_valid = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      check("R1 mode", mode_o, 0);
      check("R1 reg", reg_mode_o, 0);
      check("R1 clk_en", cpu_clk_en_o, 1);
      check("R1 retain", retain_o, 0);
      check("R1 flags", wk_flags_o, 0);
      check("R1 irq", wk_irq_o, 0);
      check("R1 cmd pulses", {cmd_exec_o, cmd_err_o, cmd_rej_o}, 0);
   endtask

   task automatic t_illegal();
      do_reset();
      stop_to(3'd0);
      check("R3 mode after tgt0", mode_o, 0);
      check("R3 err pulse", stop_err_o, 1);
      tick();
      check("R3 err one cycle", stop_err_o, 0);
      stop_to(3'd5);
      check("R3 mode after tgt5", mode_o, 0);
      check("R3 err pulse tgt5", stop_err_o, 1);
      stop_to(3'd4);
      check("R3 mode after tgt4", mode_o, 0);
   endtask

   task automatic t_lpr();
      do_reset();
      secured = 1'b0; dbg_en = 1'b1; dbg_ctl = 1'b1;
      lpr_en = 1'b1;
      tick();
      check("R4 mode lprun", mode_o, 1);
      check("R4 reg low", reg_mode_o, 1);
      stop_to(3'd2);
      check("R2 mode vstop from lprun", mode_o, 2);
      check("R5 reg stop from lprun", reg_mode_o, 2);
      check("R5 clk off from lprun", cpu_clk_en_o, 0);
      cmd(2'd0);
      check("R6 wake rejected no debug", cmd_rej_o, 1);
      check("R6 mode unchanged", mode_o, 2);
      lpr_en = 1'b0;
      do_reset();
      check("R10 reset from vstop", mode_o, 0);
      lpr_en = 1'b1;
      tick();
      lpr_en = 1'b0;
      tick();
      check("R4 back to run", mode_o, 0);
      check("R4 reg full", reg_mode_o, 0);
      secured = 1'b1; dbg_en = 1'b0; dbg_ctl = 1'b0;
   endtask

   task automatic t_lls();
      do_reset();
      stop_to(3'd3);
      check("R2 mode lls", mode_o, 3);
      check("R2 reg stop", reg_mode_o, 2);
      check("R2 retain", retain_o, 1);
      check("R2 clk off", cpu_clk_en_o, 0);
      wk_src = 4'b0001; wk_en = 4'b0000;
      tick();
      check("R8 disabled wake ignored mode", mode_o, 3);
      check("R8 disabled wake no flag", wk_flags_o, 0);
      wk_src = 4'b0101; wk_en = 4'b0100;
      tick();
      wk_src = '0;
      check("R8 wake mode run", mode_o, 0);
      check("R8 wake flag", wk_flags_o, 4);
      check("R8 wake irq", wk_irq_o, 1);
      check("R8 reg full", reg_mode_o, 0);
      check("R8 retain off", retain_o, 0);
      tick();
      check("R9 flag held", wk_flags_o, 4);
      wk_src = 4'b0001; wk_en = 4'b0001;
      tick();
      wk_src = '0;
      check("R9 wake outside lls flags", wk_flags_o, 4);
      check("R9 wake outside lls mode", mode_o, 0);
      flag_clr = 4'b0100;
      tick();
      flag_clr = '0;
      check("R9 flag cleared", wk_flags_o, 0);
      check("R9 irq cleared", wk_irq_o, 0);
      wk_en = '0;
   endtask

   task automatic t_dbg();
      do_reset();
      secured = 1'b0; dbg_en = 1'b1; dbg_ctl = 1'b1;
      stop_to(3'd2);
      check("R5 mode vstop dbg", mode_o, 2);
      check("R5 reg kept full", reg_mode_o, 0);
      check("R5 clk kept", cpu_clk_en_o, 1);
      cmd(2'd1);
      check("R6 memst err", cmd_err_o, 1);
      check("R6 memst no exec", cmd_exec_o, 0);
      check("R6 memst mode", mode_o, 2);
      cmd(2'd2);
      check("R6 other rej", cmd_rej_o, 1);
      cmd(2'd3);
      check("R6 go rej in stop", cmd_rej_o, 1);
      cmd(2'd0);
      check("R7 wake exec", cmd_exec_o, 1);
      check("R7 mode halt", mode_o, 4);
      cmd(2'd2);
      check("R7 halt other exec", cmd_exec_o, 1);
      check("R7 halt stays", mode_o, 4);
      cmd(2'd3);
      check("R7 resume exec", cmd_exec_o, 1);
      check("R7 resume run", mode_o, 0);
      dbg_ctl = 1'b0;
      stop_to(3'd2);
      check("R5 no ctl clk off", cpu_clk_en_o, 0);
      check("R5 no ctl reg stop", reg_mode_o, 2);
      cmd(2'd1);
      check("R6 memst rej no debug", cmd_rej_o, 1);
      check("R6 memst no err no debug", cmd_err_o, 0);
      secured = 1'b1; dbg_ctl = 1'b1;
      do_reset();
      stop_to(3'd3);
      check("R5 secured clk off", cpu_clk_en_o, 0);
      secured = 1'b1; dbg_en = 1'b0; dbg_ctl = 1'b0;
   endtask

   initial begin
      t_reset();
      t_illegal();
      t_lpr();
      t_lls();
      t_dbg();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule